// File: doc/BRIEF.md
# Serial Configuration Stream Loader

This block takes configuration data from a byte-wide boot memory. It turns each byte into a serial bit stream, least-significant bit first, and consumes at most one bit per clock. It hunts for a fixed 40-bit sync word and then slices the bits that follow into a fixed number of fixed-length frames. Each frame is handed to the local configuration store over a valid/ready port, together with its frame number. A 4-bit trailer closes the local image and is checked against an expected code. If it matches, `done` rises. If it does not, `err` rises instead.

In a daisy chain, a second device listens on `dout`. Until the local image is complete, `dout` idles high. Once `done` is set, every further bit the loader consumes is passed out on `dout`, one clock later, with `dout_valid` marking it. The downstream device therefore receives its own complete image: its own sync word, frames and trailer. A `prog` pulse throws away all progress and restarts the sync-word hunt.

Back-pressure rules: a byte is taken on a clock where both `in_valid` and `in_ready` are high. While `fw_valid` is high and `fw_ready` is low, the loader consumes no bits, so `in_ready` stays low once the current byte is used up. The serial output has no back-pressure.

Top module: `cfg_stream_loader`

## Requirements
- R1: A byte taken on an `in_valid`/`in_ready` handshake is used one bit per clock, starting with bit 0 and ending with bit 7. With no stall, byte handshakes in a continuous stream are exactly 8 clocks apart.
- R2: Frame data is accepted only after the last 40 bits consumed equal `SYNC_WORD`, where the earliest of those bits lies at bit 39. Any bits before the sync word are ignored.
- R3: After the sync word, `FRAME_COUNT` frames of `FRAME_LEN` bits each are collected. The first bit of a frame lands in the most significant bit of `fw_data`. `fw_index` counts from 0 upward, one step per frame.
- R4: While `fw_valid` is high and `fw_ready` is low, `fw_valid`, `fw_data` and `fw_index` hold steady and no bits are consumed. When `fw_ready` is high, each frame is presented for exactly one clock.
- R5: The 4 bits that follow the last frame are compared with `TRAILER`, the first of them at bit 3. On a match, `done` goes high and stays high until `prog` or reset.
- R6: On a trailer mismatch, `err` goes high and `done` stays low. Later bits are consumed and dropped, nothing is forwarded, and `dout` remains 1.
- R7: While `done` is low, `dout` is 1 and `dout_valid` is 0. Once `done` is high, each consumed bit appears on `dout` with `dout_valid` high on the following clock, in consumption order.
- R8: A `prog` pulse clears all progress. Afterwards `done`, `err` and `fw_valid` are low, `dout` is 1, and a fresh stream starting with its sync word loads correctly.
- R9: After reset: `done`=0, `err`=0, `fw_valid`=0, `dout`=1, `dout_valid`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prog | input | 1 | Restart request: clears progress and returns to the sync-word hunt |
| in_valid | input | 1 | Boot-memory byte is valid |
| in_ready | output | 1 | Loader can take a byte |
| in_data | input | 8 | Boot-memory byte |
| fw_valid | output | 1 | Completed frame is presented |
| fw_ready | input | 1 | Configuration store takes the frame |
| fw_index | output | IDX_W | Frame number, from 0 |
| fw_data | output | FRAME_LEN | Frame contents, first bit in the MSB |
| done | output | 1 | Local image loaded with a correct trailer |
| err | output | 1 | Trailer mismatch |
| dout | output | 1 | Serial bit passed on to the next device, idles high |
| dout_valid | output | 1 | `dout` carries a forwarded bit this clock |

## Verification
The checks assume that the source holds `in_data` steady while a byte waits for acceptance. They also assume that `prog` is a short pulse, not a level held across a whole load. The bench drives each byte from a single task that keeps `in_valid` and `in_data` fixed until the handshake completes. It raises `prog` only while no byte is in flight. Frame-port back-pressure comes from a fixed periodic pattern on `fw_ready`, so the hold rules are exercised while `in_ready` stays legal.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int SYNC_W = 40;
  localparam int TRAIL_W = 4;

  typedef enum logic [2:0] {
    LD_HUNT,
    LD_FRAME,
    LD_TRAIL,
    LD_DONE,
    LD_FAIL
  } ld_state_t;
endpackage

// File: rtl/cfg_byte_unpack.sv
module cfg_byte_unpack (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       prog,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       bit_valid,
  output logic       bit_val,
  input  logic       bit_take
);
  logic [7:0] shreg;
  logic [3:0] left;

  assign bit_valid = (left != 4'd0);
  assign bit_val   = shreg[0];
  // Ready when empty, or when the final held bit leaves this clock.
  assign in_ready  = !prog && ((left == 4'd0) || (left == 4'd1 && bit_take));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      left  <= '0;
    end else if (prog) begin
      shreg <= '0;
      left  <= '0;
    end else if (in_valid && in_ready) begin
      shreg <= in_data;
      left  <= 4'd8;
    end else if (bit_take) begin
      shreg <= {1'b0, shreg[7:1]};
      left  <= left - 4'd1;
    end
  end
endmodule

// File: rtl/cfg_frame_core.sv
module cfg_frame_core
  import cfg_loader_pkg::*;
#(
  parameter int FRAME_LEN = 16,
  parameter int FRAME_COUNT = 4,
  parameter logic [SYNC_W-1:0] SYNC_WORD = 40'hF0_5A_3C_96_E1,
  parameter logic [TRAIL_W-1:0] TRAILER = 4'hF,
  localparam int IDX_W = (FRAME_COUNT > 1) ? $clog2(FRAME_COUNT) : 1,
  localparam int BIT_W = (FRAME_LEN > 1) ? $clog2(FRAME_LEN) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 prog,
  input  logic                 bit_valid,
  input  logic                 bit_val,
  output logic                 bit_take,
  output ld_state_t            state,
  output logic                 fw_valid,
  input  logic                 fw_ready,
  output logic [IDX_W-1:0]     fw_index,
  output logic [FRAME_LEN-1:0] fw_data
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_COUNT - 1);

  logic [SYNC_W-1:0]    sync_sr;
  logic [SYNC_W-1:0]    sync_next;
  logic [FRAME_LEN-1:0] frame_sr;
  logic [TRAIL_W-1:0]   trail_sr;
  logic [TRAIL_W-1:0]   trail_next;
  logic [BIT_W-1:0]     bit_cnt;
  logic [IDX_W-1:0]     frame_idx;
  logic [1:0]           trail_cnt;

  assign bit_take   = bit_valid && !(fw_valid && !fw_ready) && !prog;
  assign sync_next  = {sync_sr[SYNC_W-2:0], bit_val};
  assign trail_next = {trail_sr[TRAIL_W-2:0], bit_val};
  // Frame port reads the shift register directly; the stall keeps it still.
  assign fw_data    = frame_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= LD_HUNT;
      sync_sr   <= '0;
      frame_sr  <= '0;
      trail_sr  <= '0;
      bit_cnt   <= '0;
      frame_idx <= '0;
      trail_cnt <= '0;
      fw_valid  <= 1'b0;
      fw_index  <= '0;
    end else if (prog) begin
      state     <= LD_HUNT;
      sync_sr   <= '0;
      frame_sr  <= '0;
      trail_sr  <= '0;
      bit_cnt   <= '0;
      frame_idx <= '0;
      trail_cnt <= '0;
      fw_valid  <= 1'b0;
      fw_index  <= '0;
    end else begin
      if (fw_valid && fw_ready) fw_valid <= 1'b0;
      if (bit_take) begin
        unique case (state)
          LD_HUNT: begin
            sync_sr <= sync_next;
            if (sync_next == SYNC_WORD) begin
              state     <= LD_FRAME;
              bit_cnt   <= '0;
              frame_idx <= '0;
            end
          end
          LD_FRAME: begin
            frame_sr <= {frame_sr[FRAME_LEN-2:0], bit_val};
            if (bit_cnt == LAST_BIT) begin
              bit_cnt  <= '0;
              fw_valid <= 1'b1;
              fw_index <= frame_idx;
              if (frame_idx == LAST_IDX) begin
                state     <= LD_TRAIL;
                trail_cnt <= '0;
              end else begin
                frame_idx <= frame_idx + 1'b1;
              end
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          LD_TRAIL: begin
            trail_sr  <= trail_next;
            trail_cnt <= trail_cnt + 2'd1;
            if (trail_cnt == 2'd3)
              state <= (trail_next == TRAILER) ? LD_DONE : LD_FAIL;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_chain_out.sv
module cfg_chain_out (
  input  logic clk,
  input  logic rst_n,
  input  logic prog,
  input  logic fwd_en,
  input  logic bit_take,
  input  logic bit_val,
  output logic dout,
  output logic dout_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout       <= 1'b1;
      dout_valid <= 1'b0;
    end else if (prog) begin
      dout       <= 1'b1;
      dout_valid <= 1'b0;
    end else begin
      dout_valid <= fwd_en && bit_take;
      if (fwd_en && bit_take) dout <= bit_val;
    end
  end
endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
  import cfg_loader_pkg::*;
#(
  parameter int FRAME_LEN = 16,
  parameter int FRAME_COUNT = 4,
  parameter logic [39:0] SYNC_WORD = 40'hF0_5A_3C_96_E1,
  parameter logic [3:0] TRAILER = 4'hF,
  localparam int IDX_W = (FRAME_COUNT > 1) ? $clog2(FRAME_COUNT) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 prog,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [7:0]           in_data,
  output logic                 fw_valid,
  input  logic                 fw_ready,
  output logic [IDX_W-1:0]     fw_index,
  output logic [FRAME_LEN-1:0] fw_data,
  output logic                 done,
  output logic                 err,
  output logic                 dout,
  output logic                 dout_valid
);
  logic      bit_valid;
  logic      bit_val;
  logic      bit_take;
  ld_state_t state;

  cfg_byte_unpack u_unpack (
    .clk(clk), .rst_n(rst_n), .prog(prog),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .bit_valid(bit_valid), .bit_val(bit_val), .bit_take(bit_take)
  );

  cfg_frame_core #(
    .FRAME_LEN(FRAME_LEN), .FRAME_COUNT(FRAME_COUNT),
    .SYNC_WORD(SYNC_WORD), .TRAILER(TRAILER)
  ) u_core (
    .clk(clk), .rst_n(rst_n), .prog(prog),
    .bit_valid(bit_valid), .bit_val(bit_val), .bit_take(bit_take),
    .state(state),
    .fw_valid(fw_valid), .fw_ready(fw_ready),
    .fw_index(fw_index), .fw_data(fw_data)
  );

  cfg_chain_out u_chain (
    .clk(clk), .rst_n(rst_n), .prog(prog),
    .fwd_en(state == LD_DONE), .bit_take(bit_take), .bit_val(bit_val),
    .dout(dout), .dout_valid(dout_valid)
  );

  assign done = (state == LD_DONE);
  assign err  = (state == LD_FAIL);
endmodule

// File: rtl/cfg_stream_loader_chk.sv
module cfg_stream_loader_chk #(
  parameter int FRAME_LEN = 16,
  parameter int FRAME_COUNT = 4,
  localparam int IDX_W = (FRAME_COUNT > 1) ? $clog2(FRAME_COUNT) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 prog,
  input logic                 in_ready,
  input logic                 fw_valid,
  input logic                 fw_ready,
  input logic [IDX_W-1:0]     fw_index,
  input logic [FRAME_LEN-1:0] fw_data,
  input logic                 done,
  input logic                 err,
  input logic                 dout,
  input logic                 dout_valid
);
  assert_frame_hold_R4: assert property (@(posedge clk) disable iff (!rst_n || prog)
    fw_valid && !fw_ready |=> fw_valid && $stable(fw_data) && $stable(fw_index));

  assert_index_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fw_valid |-> fw_index <= IDX_W'(FRAME_COUNT - 1));

  assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && !prog |=> done);

  assert_done_err_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  assert_idle_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> dout && !dout_valid);

  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prog |=> !done && !err && !fw_valid && dout && !dout_valid);

  assert_no_take_on_prog_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prog |-> !in_ready);
endmodule

bind cfg_stream_loader cfg_stream_loader_chk #(
  .FRAME_LEN(FRAME_LEN), .FRAME_COUNT(FRAME_COUNT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .prog(prog), .in_ready(in_ready),
  .fw_valid(fw_valid), .fw_ready(fw_ready), .fw_index(fw_index),
  .fw_data(fw_data), .done(done), .err(err), .dout(dout),
  .dout_valid(dout_valid)
);

// File: tb/tb_cfg_stream_loader.sv
module tb_cfg_stream_loader;
  localparam int FL = 16;
  localparam int FC = 4;
  localparam logic [39:0] SYNC = 40'hF0_5A_3C_96_E1;
  localparam logic [3:0] TRL = 4'hF;

  logic clk = 1'b0, rst_n = 1'b0, prog = 1'b0;
  logic in_valid = 1'b0, fw_ready = 1'b1;
  logic [7:0] in_data = '0;
  logic in_ready, fw_valid, done, err, dout, dout_valid;
  logic [1:0] fw_index;
  logic [FL-1:0] fw_data;

  int checks = 0, errors = 0, cyc = 0;
  logic bp_mode = 1'b0, gap_chk = 1'b0;
  logic [17:0] exp_frames[$];
  logic exp_bits[$];
  logic bitq[$];

  cfg_stream_loader #(.FRAME_LEN(FL), .FRAME_COUNT(FC), .SYNC_WORD(SYNC),
    .TRAILER(TRL)) dut (
    .clk(clk), .rst_n(rst_n), .prog(prog), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .fw_valid(fw_valid),
    .fw_ready(fw_ready), .fw_index(fw_index), .fw_data(fw_data),
    .done(done), .err(err), .dout(dout), .dout_valid(dout_valid));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // fw_ready pattern, changed at the falling edge
  always @(negedge clk) fw_ready <= bp_mode ? (cyc % 3 == 0) : 1'b1;

  // Driver: builds bits, pushes expectations, sends LSB-first bytes.
  task automatic build(input int seed, input bit bad_trailer);
    logic [3:0] t;
    bitq.delete();
    for (int i = 0; i < 4; i++) bitq.push_back(1'b1);
    for (int i = 39; i >= 0; i--) bitq.push_back(SYNC[i]);
    for (int f = 0; f < FC; f++) begin
      logic [FL-1:0] d;
      d = FL'(16'hC3A5 ^ (f * 16'h1111) ^ (seed * 16'h0F0F));
      exp_frames.push_back({2'(f), d});
      for (int i = FL-1; i >= 0; i--) bitq.push_back(d[i]);
    end
    t = bad_trailer ? 4'hB : TRL;
    for (int i = 3; i >= 0; i--) bitq.push_back(t[i]);
    for (int i = 0; i < 16; i++) begin
      logic b;
      b = 1'(((seed + 3) * (i + 5) >> 1) & 1);
      bitq.push_back(b);
      if (!bad_trailer) exp_bits.push_back(b);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    bit got;
    in_valid = 1'b1;
    in_data  = b;
    forever begin
      #1 got = in_ready;
      @(negedge clk);
      if (got) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic send_stream(input int nbytes);
    for (int k = 0; k < nbytes; k++) begin
      logic [7:0] b;
      for (int i = 0; i < 8; i++) b[i] = bitq[k*8 + i];
      send_byte(b);
    end
  endtask

  task automatic pulse_prog();
    prog = 1'b1;
    @(negedge clk);
    prog = 1'b0;
  endtask

  // Monitor: pops expected items as results appear.
  int last_acc = -1;
  logic hold_v = 1'b0;
  logic [FL-1:0] hold_d;
  logic [1:0] hold_i;
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (hold_v) begin
          chk(fw_valid && fw_data == hold_d && fw_index == hold_i, "R4 hold",
              {fw_index, fw_data}, {hold_i, hold_d});
        end
        hold_v = fw_valid && !fw_ready;
        hold_d = fw_data;
        hold_i = fw_index;
        if (fw_valid && fw_ready) begin
          if (exp_frames.size() == 0) chk(0, "R3 unexpected frame", fw_data, 0);
          else begin
            logic [17:0] e;
            e = exp_frames.pop_front();
            chk({fw_index, fw_data} == e, "R2/R3 frame", {fw_index, fw_data}, e);
          end
        end
        if (!done) chk(dout && !dout_valid, "R7 idle high", {dout, dout_valid}, 2);
        if (dout_valid) begin
          if (exp_bits.size() == 0) chk(0, "R6/R7 unexpected forward", dout, 1);
          else begin
            logic e;
            e = exp_bits.pop_front();
            chk(dout == e, "R7 forward bit", dout, e);
          end
        end
        if (in_valid && in_ready) begin
          if (gap_chk && last_acc >= 0) chk(cyc - last_acc == 8, "R1 byte gap", cyc - last_acc, 8);
          last_acc = cyc;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !err && !fw_valid && dout && !dout_valid && in_ready, "R9 reset state",
        {done, err, fw_valid, dout, dout_valid, in_ready}, 6'b000101);
    rst_n = 1'b1;
    @(negedge clk);

    // Run 1: clean load, no stall
    gap_chk = 1'b1;
    build(1, 1'b0);
    send_stream(16);
    gap_chk = 1'b0;
    last_acc = -1;
    repeat (20) @(negedge clk);
    chk(done && !err, "R5 done after good trailer", {done, err}, 2);
    chk(exp_frames.size() == 0, "R3 all frames seen", exp_frames.size(), 0);
    chk(exp_bits.size() == 0, "R7 all bits forwarded", exp_bits.size(), 0);

    // Run 2: restart, then bad trailer under back-pressure
    pulse_prog();
    #2 chk(!done && !err && dout && !fw_valid, "R8 cleared", {done, err, dout}, 1);
    @(negedge clk);
    bp_mode = 1'b1;
    build(2, 1'b1);
    send_stream(16);
    repeat (20) @(negedge clk);
    chk(err && !done, "R6 error on bad trailer", {err, done}, 2);
    chk(dout == 1'b1, "R6 dout stays high", dout, 1);
    chk(exp_frames.size() == 0, "R4 frames under stall", exp_frames.size(), 0);

    // Run 3: abort inside the sync word, then full load with stall
    pulse_prog();
    #2 chk(!err && !done, "R8 error cleared", {err, done}, 0);
    @(negedge clk);
    build(3, 1'b0);
    exp_frames.delete();
    exp_bits.delete();
    send_stream(4);
    pulse_prog();
    build(4, 1'b0);
    send_stream(16);
    repeat (30) @(negedge clk);
    chk(done && !err, "R8 reload after prog", {done, err}, 2);
    chk(exp_frames.size() == 0 && exp_bits.size() == 0, "R3/R7 reload complete",
        exp_frames.size() + exp_bits.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule